// File: doc/BRIEF.md
# Task priority interrupt gate

This block stands between a group of external interrupt sources and the processor's interrupt-accept logic. Each source raises a one-cycle set pulse that marks it pending, and each source presents an 8-bit vector whose upper four bits give its priority class. A 4-bit task priority register holds a threshold. Any pending request whose class is at or below that threshold is held back. Among the requests that pass, the block forwards one winner as a registered valid flag, vector and source index.

Software running a high-priority task raises the threshold so that less urgent interrupts wait. It lowers the threshold again when the task ends. An acknowledge from the accept logic consumes the forwarded request. The winner's pending bit is cleared, and the next winner appears one cycle later. A request that becomes blocked while it is being shown is withdrawn without being consumed, and it stays pending.

Top module: `tpr_irq_gate`

## Requirements
- R1: After reset the task priority is 0, no source is pending and `irq_valid` is 0.
- R2: The class of a request is bits 7:4 of its vector. A pending request is eligible only when its class is strictly greater than the task priority.
- R3: With task priority 0, classes 1 to 15 are forwarded. A request of class 0 is never forwarded.
- R4: With task priority 15, no request is forwarded.
- R5: Among eligible requests, the one with the highest class is forwarded.
- R6: Within one class, the higher vector number wins. When two sources show the same vector, the lower source index wins.
- R7: The outputs are registered. A set pulse or a task priority write sampled at clock edge k is reflected on the outputs after edge k+1.
- R8: If a forwarded request becomes blocked by a task priority write, `irq_valid` drops without an acknowledge. The request stays pending and is forwarded again once the threshold falls below its class.
- R9: An acknowledge while `irq_valid` is 1 clears the forwarded source's pending bit at that edge. `irq_valid` is 0 in the next cycle, and the next winner is shown one cycle after that.
- R10: An acknowledge while `irq_valid` is 0 has no effect on any pending bit.
- R11: A set pulse for the source being cleared by an acknowledge at the same edge leaves that source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | NSRC | One bit per source; 1 marks that source pending |
| req_vec | input | NSRC x 8 | Vector of each source; bits 7:4 are its class |
| tpr_we | input | 1 | Write strobe for the task priority |
| tpr_wdata | input | 4 | New task priority value |
| irq_ack | input | 1 | Accept logic takes the forwarded request |
| irq_valid | output | 1 | A request is being forwarded |
| irq_vector | output | 8 | Vector of the forwarded request |
| irq_src | output | clog2(NSRC) | Source index of the forwarded request |

## Verification
State errors in this gate surface at the outputs within one or two cycles. A pending bit that is lost or left set shows up as a missing or repeated forward once the higher requests are drained. A stale threshold shows up as a forward of a blocked class, or as a missing forward, one cycle after the write. The bench's reference model tracks pending bits and the threshold as plain integers, and it compares valid, vector and source on every cycle. Any divergence is therefore reported in the cycle where it first becomes visible.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
package tpg_pkg;
  localparam int VEC_W = 8;
  localparam int CLS_W = 4;
  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  function automatic cls_t class_of(vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction
endpackage

// File: rtl/tpg_state.sv
`timescale 1ns/1ps
module tpg_state
  import tpg_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_set,
  input  logic            tpr_we,
  input  cls_t            tpr_wdata,
  input  logic            clr_en,
  input  logic [SW-1:0]   clr_idx,
  output logic [NSRC-1:0] pend_q,
  output cls_t            tpr_q
);
  logic [NSRC-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      tpr_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | req_set;
      if (tpr_we) tpr_q <= tpr_wdata;
    end
  end

  // R1: state after reset
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_q == '0 && tpr_q == '0));

  // R9: acknowledged source no longer pending unless re-set (R11)
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !req_set[clr_idx]) |=> !pend_q[$past(clr_idx)]);

  // R11: a set pulse always leaves the source pending
  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (req_set != '0) |=> ((pend_q & $past(req_set)) == $past(req_set)));
endmodule

// File: rtl/tpg_elig.sv
`timescale 1ns/1ps
module tpg_elig
  import tpg_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0]            pend,
  input  logic [NSRC-1:0][VEC_W-1:0] vecs,
  input  cls_t                       tpr,
  output logic [NSRC-1:0]            elig
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    // class strictly above threshold; class 0 can never exceed it
    assign elig[g] = pend[g] && (class_of(vecs[g]) > tpr);
  end
endmodule

// File: rtl/tpg_pick.sv
`timescale 1ns/1ps
module tpg_pick
  import tpg_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]            elig,
  input  logic [NSRC-1:0][VEC_W-1:0] vecs,
  output logic                       found,
  output vec_t                       best_vec,
  output logic [SW-1:0]              best_idx
);
  // Class sits in the top bits, so the largest full vector is the
  // highest class and, inside it, the highest number. Strict compare
  // keeps the lowest index on identical vectors.
  always_comb begin
    found    = 1'b0;
    best_vec = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!found || vecs[i] > best_vec)) begin
        found    = 1'b1;
        best_vec = vecs[i];
        best_idx = SW'(i);
      end
    end
  end
endmodule

// File: rtl/tpr_irq_gate.sv
`timescale 1ns/1ps
module tpr_irq_gate
  import tpg_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NSRC-1:0]            req_set,
  input  logic [NSRC-1:0][VEC_W-1:0] req_vec,
  input  logic                       tpr_we,
  input  logic [CLS_W-1:0]           tpr_wdata,
  input  logic                       irq_ack,
  output logic                       irq_valid,
  output logic [VEC_W-1:0]           irq_vector,
  output logic [SW-1:0]              irq_src
);
  logic [NSRC-1:0] pend_q;
  cls_t            tpr_q;
  logic [NSRC-1:0] elig;
  logic            found;
  vec_t            best_vec;
  logic [SW-1:0]   best_idx;
  logic            ack_fire;

  assign ack_fire = irq_ack && irq_valid;

  tpg_state #(.NSRC(NSRC)) u_state (
    .clk(clk), .rst(rst), .req_set(req_set),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
    .clr_en(ack_fire), .clr_idx(irq_src),
    .pend_q(pend_q), .tpr_q(tpr_q)
  );

  tpg_elig #(.NSRC(NSRC)) u_elig (
    .pend(pend_q), .vecs(req_vec), .tpr(tpr_q), .elig(elig)
  );

  tpg_pick #(.NSRC(NSRC)) u_pick (
    .elig(elig), .vecs(req_vec),
    .found(found), .best_vec(best_vec), .best_idx(best_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      irq_src    <= '0;
    end else if (ack_fire) begin
      irq_valid  <= 1'b0;
    end else begin
      irq_valid  <= found;
      irq_vector <= best_vec;
      irq_src    <= best_idx;
    end
  end

  // R2: a forward always clears the threshold it was judged against
  assert_above_tpr_R2: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (class_of(irq_vector) > $past(tpr_q)));

  // R3: class 0 never leaves the gate
  assert_no_class0_R3: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (class_of(irq_vector) != '0));

  // R9: one idle cycle after an accepted acknowledge
  assert_gap_after_ack_R9: assert property (@(posedge clk) disable iff (rst)
    ack_fire |=> !irq_valid);

  // R7: forwarded source was pending at the sampling edge
  assert_src_pending_R7: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> ((($past(pend_q) >> irq_src) & NSRC'(1)) != '0));
endmodule

// File: tb/test_tpr_irq_gate.sv
`timescale 1ns/1ps
module test_tpr_irq_gate;
  localparam int N  = 8;
  localparam int SW = $clog2(N);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [N-1:0]         req_set = '0;
  logic [N-1:0][7:0]    req_vec = '0;
  logic                 tpr_we = 1'b0;
  logic [3:0]           tpr_wdata = '0;
  logic                 irq_ack = 1'b0;
  logic                 irq_valid;
  logic [7:0]           irq_vector;
  logic [SW-1:0]        irq_src;

  int total = 0;
  int bad   = 0;

  // reference model state
  bit m_pend[N];
  int m_tpr;
  bit m_valid;
  int m_vec;
  int m_src;

  always #4 clk = ~clk;

  tpr_irq_gate #(.NSRC(N)) i_tpr_irq_gate (
    .clk(clk), .rst(rst), .req_set(req_set), .req_vec(req_vec),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .irq_ack(irq_ack),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_src(irq_src)
  );

  task automatic check(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: compare at negedge, drive, advance model to next edge
  task automatic step(string tag, logic [N-1:0] set, bit ack,
                      bit we, int wd);
    int best;
    @(negedge clk);
    check(tag, int'(irq_valid), int'(m_valid), "valid");
    if (m_valid) begin
      check(tag, int'(irq_vector), m_vec, "vector");
      check(tag, int'(irq_src), m_src, "source");
    end
    req_set   = set;
    irq_ack   = ack;
    tpr_we    = we;
    tpr_wdata = 4'(wd);
    best = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && int'(req_vec[i][7:4]) > m_tpr)
        if (best < 0 || int'(req_vec[i]) > int'(req_vec[best])) best = i;
    if (ack && m_valid) begin
      m_pend[m_src] = 1'b0;
      m_valid = 1'b0;
    end else begin
      m_valid = (best >= 0);
      if (best >= 0) begin
        m_vec = int'(req_vec[best]);
        m_src = best;
      end
    end
    for (int i = 0; i < N; i++) if (set[i]) m_pend[i] = 1'b1;
    if (we) m_tpr = wd;
  endtask

  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) step(tag, '0, 1'b0, 1'b0, 0);
  endtask

  task automatic drain(string tag, int n);
    for (int k = 0; k < n; k++) step(tag, '0, m_valid, 1'b0, 0);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_pend[i] = 1'b0;
    m_tpr = 0; m_valid = 1'b0; m_vec = 0; m_src = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", int'(irq_valid), 0, "valid after reset");

    // R1 R3 R7: class 1 passes under the reset threshold, two edges later
    req_vec[0] = 8'h12;
    step("R7", 8'h01, 1'b0, 1'b0, 0);
    step("R7", '0, 1'b0, 1'b0, 0);
    step("R3", '0, 1'b0, 1'b0, 0);
    check("R3", int'(irq_vector), 8'h12, "class 1 forwarded");
    drain("R9", 3);

    // R3: class 0 stays pending and never shows
    req_vec[1] = 8'h05;
    step("R3", 8'h02, 1'b0, 1'b0, 0);
    idle("R3", 3);

    // R5: highest class wins, then the others in order
    req_vec[2] = 8'h31; req_vec[3] = 8'h9C; req_vec[4] = 8'h60;
    step("R5", 8'h1C, 1'b0, 1'b0, 0);
    idle("R5", 2);
    check("R5", int'(irq_vector), 8'h9C, "top class");
    drain("R5", 8);

    // R6: same class, higher number; identical vectors, lower index
    req_vec[2] = 8'h74; req_vec[3] = 8'h7A;
    req_vec[4] = 8'h50; req_vec[6] = 8'h50;
    step("R6", 8'h5C, 1'b0, 1'b0, 0);
    idle("R6", 2);
    check("R6", int'(irq_vector), 8'h7A, "higher number");
    drain("R6", 6);
    check("R6", int'(irq_src), 4, "lower index on tie");
    drain("R6", 4);

    // R4: threshold 15 blocks all, threshold 8 releases only above 8
    step("R4", '0, 1'b0, 1'b1, 15);
    req_vec[2] = 8'hF0; req_vec[3] = 8'h81; req_vec[5] = 8'h93;
    step("R4", 8'h2C, 1'b0, 1'b0, 0);
    idle("R4", 4);
    step("R2", '0, 1'b0, 1'b1, 8);
    idle("R2", 2);
    drain("R2", 6);
    step("R2", '0, 1'b0, 1'b1, 0);
    drain("R2", 5);

    // R8: a shown request is withdrawn by a raise, then reappears
    req_vec[7] = 8'h5E;
    step("R8", 8'h80, 1'b0, 1'b0, 0);
    idle("R8", 2);
    check("R8", int'(irq_valid), 1, "shown before raise");
    step("R8", '0, 1'b0, 1'b1, 5);
    idle("R8", 3);
    check("R8", int'(irq_valid), 0, "withdrawn");
    step("R8", '0, 1'b0, 1'b1, 4);
    idle("R8", 2);
    check("R8", int'(irq_vector), 8'h5E, "returned");
    drain("R8", 3);

    // R10: acknowledge with nothing shown leaves pending state alone
    step("R10", '0, 1'b0, 1'b1, 15);
    req_vec[5] = 8'hA3;
    step("R10", 8'h20, 1'b0, 1'b0, 0);
    step("R10", '0, 1'b1, 1'b0, 0);
    step("R10", '0, 1'b1, 1'b0, 0);
    step("R10", '0, 1'b0, 1'b1, 0);
    idle("R10", 2);
    check("R10", int'(irq_vector), 8'hA3, "still pending");

    // R11: set and acknowledge of the same source at one edge
    step("R11", 8'h20, 1'b1, 1'b0, 0);
    idle("R11", 2);
    check("R11", int'(irq_valid), 1, "re-set survives clear");
    drain("R11", 4);

    // R9: back-to-back drain of several sources
    req_vec[0] = 8'h21; req_vec[3] = 8'hD0; req_vec[6] = 8'h44;
    step("R9", 8'h49, 1'b0, 1'b0, 0);
    idle("R9", 2);
    drain("R9", 10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule